// File: doc/BRIEF.md
# Descriptor-Table Sector DMA Engine

This block moves disk sectors to or from host memory. Host memory holds a table of
eight-byte region descriptors. The device state machine first arms the engine for
a command. Arming gives a sector count, a starting logical block number and a
direction. The host then writes its start bit. From that point the engine reads
descriptors one at a time over a single-beat memory master port. For each descriptor
it moves data one whole sector at a time, and between sectors it waits a fixed disk
latency. When the memory port reports busy, the engine backs off for a fixed number
of cycles and then tries the same access again.

The engine keeps a count of the sectors the command still owes. It checks every
descriptor against that count. It stops after the descriptor that carries the
end-of-table flag and reports one of two results to the device state machine: a
one-cycle `done_o` when the table covered the command exactly, or a one-cycle
`err_o` otherwise. A host abort also ends the run with `err_o`, and so does a start
that arrives at the wrong moment.

States:
- `S_IDLE`: waiting to be armed.
- `S_ARMED`: start pending.
- `S_FETCH` / `S_FWAIT`: issue and capture one descriptor dword.
- `S_CHECK`: decode and validate the descriptor.
- `S_LAT`: per-sector disk latency.
- `S_XFER` / `S_XWAIT`: issue a data beat and, for disk writes, capture it.
- `S_BACKOFF`: memory busy.
- `S_DONE`, `S_ERR`: one-cycle result states.

Transitions:
- `S_IDLE` goes to `S_ARMED` on arm.
- `S_ARMED` goes to `S_FETCH` on a valid start.
- `S_FETCH` goes to `S_FWAIT`, or to `S_BACKOFF` when busy.
- `S_FWAIT` goes back to `S_FETCH` for the second dword, then to `S_CHECK`.
- `S_CHECK` goes to `S_LAT`, or to `S_ERR`.
- `S_LAT` goes to `S_XFER`.
- `S_XFER` goes to `S_XWAIT`, to `S_BACKOFF`, or to the after-beat target.
- `S_XWAIT` goes to the after-beat target.
- `S_BACKOFF` goes back to `S_FETCH` or `S_XFER`.
- The after-beat target is the next beat in `S_XFER`, `S_LAT`, `S_FETCH`, `S_DONE` or `S_ERR`.
- `S_DONE` and `S_ERR` go to `S_IDLE`.

Top module: `prd_dma_engine`

## Requirements
- R1: After reset, `done_o`, `err_o`, `mem_req_o` and `dsk_we_o` are low.
- R2: A start is honoured only in `S_ARMED` with `xfer_phase_i` high. A start seen in any other state, including idle or armed with `xfer_phase_i` low, gives a one-cycle `err_o` in the cycle after that edge.
- R3: A descriptor is two dwords. Dword 0 is the base address, with bits 1:0 ignored. Dword 1 holds the byte count in bits 15:0, where 0 means 65536, and the end-of-table flag in bit 31. The first descriptor is read at `table_base_i`, and each later one 8 bytes further on.
- R4: A descriptor fetch is two reads, at the pointer and at the pointer plus 4. Read data arrives in the cycle after the request. With the port free, fetching and checking a descriptor takes 5 cycles.
- R5: If `mem_busy_i` is high when an access is due, no request is made. The engine waits `BACKOFF_CYC` cycles and retries, so one busy sample costs `BACKOFF_CYC`+1 cycles.
- R6: Each sector waits `SECTOR_LAT` cycles before its first beat. Its beats go to consecutive word addresses from the descriptor base. The block number goes up by one per sector.
- R7: With `arm_to_mem_i`=1 (disk read), each beat is one memory write of `dsk_rdata_i` and takes 1 cycle. With `arm_to_mem_i`=0 (disk write), each beat is a memory read, followed one cycle later by a `dsk_we_o` write of that data, and takes 2 cycles.
- R8: A descriptor whose byte count is not a whole number of sectors, or that covers more sectors than remain, ends the run with `err_o` and moves no data for that descriptor.
- R9: After the last sector of the end-of-table descriptor, `done_o` pulses in the next cycle if no sectors remain. Otherwise `err_o` pulses.
- R10: `abort_i` in any armed or active state gives `err_o` in the next cycle, and no further memory requests follow. In idle, `abort_i` is ignored.
- R11: Arming loads the sector count (0 means 256), the start block and the direction, and is accepted only in idle.
- R12: `done_o` and `err_o` are never high together, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Arm for a new command |
| arm_to_mem_i | input | 1 | 1: disk to memory, 0: memory to disk |
| arm_sectors_i | input | 8 | Sector count of the command, 0 = 256 |
| arm_lba_i | input | LBA_W | First logical block |
| xfer_phase_i | input | 1 | Device state machine is in its DMA transfer state |
| table_base_i | input | 32 | Address of the descriptor table |
| start_i | input | 1 | Host start bit pulse |
| abort_i | input | 1 | Host abort pulse |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_busy_i | input | 1 | Memory port busy |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read |
| dsk_lba_o | output | LBA_W | Current block |
| dsk_word_o | output | WIDX_W | Word within the sector |
| dsk_rdata_i | input | 32 | Disk data for the addressed word |
| dsk_we_o | output | 1 | Disk word write |
| dsk_wdata_o | output | 32 | Disk write data |
| done_o | output | 1 | Successful completion pulse |
| err_o | output | 1 | Error or abort pulse |

## Verification
The hardest case to reach is a run in which the table and the command's sector count disagree only at the very end. In that case the end-of-table flag arrives while sectors are still owed, or the last descriptor asks for more than remains. Data has then already moved, and only the final result tells a correct design from a wrong one. The stimulus table builds three-descriptor tables whose sector sums fall short of, equal or exceed the armed count. Each run checks the exact cycle of the result pulse as well as where every beat landed. A forced busy sample on the first fetch exercises the backoff path. A second arm during the armed state shows that the later block number was not taken.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ARMED,
        S_FETCH,
        S_FWAIT,
        S_CHECK,
        S_LAT,
        S_XFER,
        S_XWAIT,
        S_BACKOFF,
        S_DONE,
        S_ERR
    } dma_state_e;

    localparam int DESC_BYTES = 8;
    localparam int EOT_POS    = 31;
    localparam int CNT_W      = 17;   // byte count incl. the 64 KiB case
    localparam int REM_W      = 9;    // up to 256 sectors

endpackage

// File: rtl/dma_down_timer.sv
module dma_down_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (load_i)       cnt <= load_val_i;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);

    AST_TMR_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);   // R6

endmodule

// File: rtl/prd_desc_check.sv
module prd_desc_check
    import prd_dma_pkg::*;
#(
    parameter int SECTOR_BYTES = 512
) (
    input  logic [31:0]      dw0_i,
    input  logic [31:0]      dw1_i,
    input  logic [REM_W-1:0] rem_i,
    output logic [31:0]      base_o,
    output logic [CNT_W-1:0] nsec_o,
    output logic             eot_o,
    output logic             bad_o
);

    localparam int SB_LOG = $clog2(SECTOR_BYTES);

    logic [CNT_W-1:0] bytes;
    logic             unused_desc_bits;

    always_comb begin
        bytes  = (dw1_i[15:0] == 16'h0) ? CNT_W'(17'h10000) : {1'b0, dw1_i[15:0]};
        nsec_o = bytes >> SB_LOG;
        base_o = {dw0_i[31:2], 2'b00};
        eot_o  = dw1_i[EOT_POS];
        bad_o  = (bytes[SB_LOG-1:0] != '0) || (nsec_o > CNT_W'(rem_i));
    end

    assign unused_desc_bits = ^{dw0_i[1:0], dw1_i[30:16]};

    always_comb begin
        AST_NSEC_NONZERO: assert (nsec_o != '0 || bytes[SB_LOG-1:0] != '0);   // R3
    end

endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
    import prd_dma_pkg::*;
#(
    parameter int LBA_W        = 28,
    parameter int SECTOR_BYTES = 512,
    parameter int SECTOR_LAT   = 8,
    parameter int BACKOFF_CYC  = 4,
    localparam int WPS         = SECTOR_BYTES / 4,
    localparam int WIDX_W      = (WPS > 1) ? $clog2(WPS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic              arm_to_mem_i,
    input  logic [7:0]        arm_sectors_i,
    input  logic [LBA_W-1:0]  arm_lba_i,
    input  logic              xfer_phase_i,
    input  logic [31:0]       table_base_i,
    input  logic              start_i,
    input  logic              abort_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [31:0]       mem_addr_o,
    output logic [31:0]       mem_wdata_o,
    input  logic              mem_busy_i,
    input  logic [31:0]       mem_rdata_i,
    output logic [LBA_W-1:0]  dsk_lba_o,
    output logic [WIDX_W-1:0] dsk_word_o,
    input  logic [31:0]       dsk_rdata_i,
    output logic              dsk_we_o,
    output logic [31:0]       dsk_wdata_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int TMR_MAX = (SECTOR_LAT > BACKOFF_CYC) ? SECTOR_LAT : BACKOFF_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    dma_state_e state, nxt, after_beat;

    logic              to_mem, ret_xfer, fidx, eot_q;
    logic [REM_W-1:0]  rem_sec;
    logic [LBA_W-1:0]  lba;
    logic [31:0]       ptr, addr, dw0, dw1;
    logic [CNT_W-1:0]  desc_sec;
    logic [WIDX_W-1:0] widx;

    logic [31:0]       dec_base;
    logic [CNT_W-1:0]  dec_nsec;
    logic              dec_eot, dec_bad;
    logic              lat_zero, bo_zero, lat_load, bo_load;
    logic              kill, beat_last, beat_step;
    logic              unused_base_bits;

    assign unused_base_bits = ^table_base_i[1:0];

    prd_desc_check #(.SECTOR_BYTES(SECTOR_BYTES)) u_check (
        .dw0_i (dw0),
        .dw1_i (dw1),
        .rem_i (rem_sec),
        .base_o(dec_base),
        .nsec_o(dec_nsec),
        .eot_o (dec_eot),
        .bad_o (dec_bad)
    );

    dma_down_timer #(.W(TMR_W)) u_lat_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (lat_load),
        .load_val_i(TMR_W'(SECTOR_LAT - 1)),
        .zero_o    (lat_zero)
    );

    dma_down_timer #(.W(TMR_W)) u_bo_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (bo_load),
        .load_val_i(TMR_W'(BACKOFF_CYC - 1)),
        .zero_o    (bo_zero)
    );

    assign kill      = abort_i | start_i;
    assign beat_last = (widx == WIDX_W'(WPS - 1));
    assign beat_step = !kill && ((state == S_XFER && to_mem && !mem_busy_i) ||
                                 (state == S_XWAIT));
    assign lat_load  = (nxt == S_LAT) && (state != S_LAT);
    assign bo_load   = (nxt == S_BACKOFF) && (state != S_BACKOFF);

    // where a finished beat leads
    always_comb begin
        if (!beat_last)
            after_beat = S_XFER;
        else if (desc_sec == CNT_W'(1))
            after_beat = !eot_q ? S_FETCH : ((rem_sec == REM_W'(1)) ? S_DONE : S_ERR);
        else
            after_beat = S_LAT;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start_i)    nxt = S_ERR;
                else if (arm_i) nxt = S_ARMED;
            end
            S_ARMED: begin
                if (abort_i)      nxt = S_ERR;
                else if (start_i) nxt = xfer_phase_i ? S_FETCH : S_ERR;
            end
            S_FETCH:   nxt = kill ? S_ERR : (mem_busy_i ? S_BACKOFF : S_FWAIT);
            S_FWAIT:   nxt = kill ? S_ERR : (fidx ? S_CHECK : S_FETCH);
            S_CHECK:   nxt = kill ? S_ERR : (dec_bad ? S_ERR : S_LAT);
            S_LAT:     nxt = kill ? S_ERR : (lat_zero ? S_XFER : S_LAT);
            S_XFER: begin
                if (kill)            nxt = S_ERR;
                else if (mem_busy_i) nxt = S_BACKOFF;
                else if (!to_mem)    nxt = S_XWAIT;
                else                 nxt = after_beat;
            end
            S_XWAIT:   nxt = kill ? S_ERR : after_beat;
            S_BACKOFF: nxt = kill ? S_ERR : (bo_zero ? (ret_xfer ? S_XFER : S_FETCH) : S_BACKOFF);
            S_DONE:    nxt = S_IDLE;
            S_ERR:     nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            to_mem   <= 1'b0;
            ret_xfer <= 1'b0;
            fidx     <= 1'b0;
            eot_q    <= 1'b0;
            rem_sec  <= '0;
            lba      <= '0;
            ptr      <= '0;
            addr     <= '0;
            dw0      <= '0;
            dw1      <= '0;
            desc_sec <= '0;
            widx     <= '0;
        end else begin
            if (state == S_IDLE && arm_i && !start_i) begin
                to_mem  <= arm_to_mem_i;
                rem_sec <= (arm_sectors_i == 8'd0) ? REM_W'(256) : REM_W'(arm_sectors_i);
                lba     <= arm_lba_i;
            end
            if (state == S_ARMED && start_i) begin
                ptr  <= {table_base_i[31:2], 2'b00};
                fidx <= 1'b0;
            end
            if (state == S_FWAIT) begin
                if (!fidx) begin
                    dw0  <= mem_rdata_i;
                    fidx <= 1'b1;
                end else begin
                    dw1  <= mem_rdata_i;
                    fidx <= 1'b0;
                    ptr  <= ptr + 32'(DESC_BYTES);
                end
            end
            if (state == S_CHECK) begin
                addr     <= dec_base;
                desc_sec <= dec_nsec;
                eot_q    <= dec_eot;
                widx     <= '0;
            end
            if (bo_load)
                ret_xfer <= (state == S_XFER);
            if (beat_step) begin
                addr <= addr + 32'd4;
                if (beat_last) begin
                    widx     <= '0;
                    lba      <= lba + 1'b1;
                    rem_sec  <= rem_sec - 1'b1;
                    desc_sec <= desc_sec - 1'b1;
                end else begin
                    widx <= widx + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = addr;
        mem_wdata_o = dsk_rdata_i;
        dsk_we_o    = 1'b0;
        dsk_wdata_o = mem_rdata_i;
        dsk_lba_o   = lba;
        dsk_word_o  = widx;
        done_o      = 1'b0;
        err_o       = 1'b0;
        unique case (state)
            S_FETCH: begin
                mem_req_o  = !mem_busy_i && !kill;
                mem_addr_o = ptr + (fidx ? 32'd4 : 32'd0);
            end
            S_XFER: begin
                mem_req_o = !mem_busy_i && !kill;
                mem_we_o  = to_mem;
            end
            S_XWAIT: dsk_we_o = !kill;
            S_DONE:  done_o   = 1'b1;
            S_ERR:   err_o    = 1'b1;
            default: ;
        endcase
    end

    AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !mem_busy_i);                                   // R5
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));                    // R3
    AST_DONE_NOTHING_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem_sec == '0));                                  // R9
    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));                                          // R12
    AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || err_o) |=> !(done_o || err_o));                    // R12
    AST_QUIET_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !mem_req_o);                                        // R10
    AST_LBA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_step && beat_last) |=> (dsk_lba_o == $past(dsk_lba_o) + 1'b1));  // R6

endmodule

// File: tb/tb_prd_dma_engine.sv
`timescale 1ns/1ps
module tb_prd_dma_engine;

    localparam int LBA_W = 28;
    localparam int SB    = 16;
    localparam int LAT   = 3;
    localparam int BO    = 4;
    localparam int WPS   = SB / 4;
    localparam logic [27:0] LBA0 = 28'h0000120;

    // vector: {bad, to_mem, nsec[7:0], c0, c1, c2}
    localparam int NV = 7;
    localparam logic [57:0] VECS [NV] = '{
        {1'b0, 1'b1, 8'd4, 16'd32, 16'd16, 16'd16},  // R7 R6 disk->mem
        {1'b0, 1'b0, 8'd4, 16'd16, 16'd16, 16'd32},  // R7 mem->disk
        {1'b0, 1'b1, 8'd3, 16'd16, 16'd16, 16'd16},  // R9 exact fit
        {1'b1, 1'b1, 8'd2, 16'd16, 16'd16, 16'd16},  // R8 too many sectors
        {1'b1, 1'b1, 8'd5, 16'd16, 16'd16, 16'd16},  // R9 eot while owed
        {1'b1, 1'b1, 8'd4, 16'd20, 16'd16, 16'd16},  // R8 partial sector
        {1'b1, 1'b1, 8'd0, 16'd0,  16'd16, 16'd16}   // R3 zero = 64 KiB
    };

    logic clk = 0, rst_n = 0;
    logic arm = 0, arm_to_mem = 0, phase = 0, start = 0, abort = 0, busy = 0;
    logic [7:0]  arm_sec = 0;
    logic [27:0] arm_lba = 0;
    logic [31:0] tbase = 32'h100;
    logic        mem_req, mem_we, dsk_we, done, err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, dsk_wdata, dsk_rdata;
    logic [27:0] dsk_lba;
    logic [1:0]  dsk_word;

    logic [31:0] mem [0:1023];
    logic [31:0] dsk [0:63];

    int total = 0, bad = 0;

    always #4 clk = ~clk;

    prd_dma_engine #(.LBA_W(LBA_W), .SECTOR_BYTES(SB), .SECTOR_LAT(LAT),
                     .BACKOFF_CYC(BO)) dut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .arm_to_mem_i(arm_to_mem),
        .arm_sectors_i(arm_sec), .arm_lba_i(arm_lba), .xfer_phase_i(phase),
        .table_base_i(tbase), .start_i(start), .abort_i(abort),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_busy_i(busy), .mem_rdata_i(mem_rdata),
        .dsk_lba_o(dsk_lba), .dsk_word_o(dsk_word), .dsk_rdata_i(dsk_rdata),
        .dsk_we_o(dsk_we), .dsk_wdata_o(dsk_wdata), .done_o(done), .err_o(err));

    assign dsk_rdata = {dsk_lba[15:0], 8'h5A, 6'b0, dsk_word};

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:2]];
        end
        if (dsk_we) dsk[6'((dsk_lba - LBA0) * WPS) + 6'(dsk_word)] <= dsk_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_arm(input bit tm, input logic [7:0] ns, input logic [27:0] lb);
        @(negedge clk);
        arm = 1; arm_to_mem = tm; arm_sec = ns; arm_lba = lb;
        @(negedge clk);
        arm = 0;
    endtask

    task automatic run(input logic [57:0] v, input bit busy_first, input bit rearm);
        bit tm, vbad, got_done, got_err;
        logic [15:0] c [3];
        int n, sect, exp_n, mism, gs;
        vbad = v[57]; tm = v[56];
        c[0] = v[47:32]; c[1] = v[31:16]; c[2] = v[15:0];
        @(negedge clk);
        for (int i = 256; i < 1024; i++) mem[i] = tm ? 32'h0 : (32'hC0DE0000 ^ (i * 4));
        for (int i = 0; i < 64; i++) dsk[i] = 32'h0;
        for (int d = 0; d < 3; d++) begin
            mem[64 + 2*d] = 32'h400 * (d + 1);
            mem[65 + 2*d] = {(d == 2), 15'b0, c[d]};
        end
        do_arm(tm, v[55:48], LBA0);
        if (rearm) do_arm(tm, v[55:48], LBA0 + 28'd8);
        phase = 1; start = 1;
        @(posedge clk);
        n = 0; got_done = 0; got_err = 0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            start = 0;
            busy = busy_first && (n == 0);
            if (done || err) begin
                got_done = done; got_err = err;
                break;
            end
            @(posedge clk);
            n++;
        end
        busy = 0; phase = 0;
        sect = (c[0] + c[1] + c[2]) / SB;
        exp_n = 15 + sect * (LAT + WPS * (tm ? 1 : 2)) + (busy_first ? BO + 1 : 0);
        chk(got_done == !vbad && got_err == vbad, vbad ? "R8/R9 err outcome" : "R9 done outcome",
            {30'b0, got_err, got_done}, {30'b0, vbad, !vbad});
        if (!vbad) begin
            chk(n == exp_n, busy_first ? "R5 backoff timing" : "R4/R9 done timing", n, exp_n);
            mism = 0; gs = 0;
            for (int d = 0; d < 3; d++)
                for (int s = 0; s < c[d] / SB; s++) begin
                    for (int w = 0; w < WPS; w++) begin
                        int a;
                        a = 32'h400 * (d + 1) + s * SB + w * 4;
                        if (tm) begin
                            if (mem[a/4] != {16'(LBA0 + gs), 8'h5A, 6'b0, 2'(w)}) mism++;
                        end else begin
                            if (dsk[gs*WPS + w] != (32'hC0DE0000 ^ a)) mism++;
                        end
                    end
                    gs++;
                end
            chk(mism == 0, rearm ? "R11 arm ignored once armed" : "R6/R7 data placement",
                mism, 0);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int q;
        repeat (3) @(negedge clk);
        chk(!done && !err && !mem_req && !dsk_we, "R1 reset outputs",
            {28'b0, done, err, mem_req, dsk_we}, 0);
        rst_n = 1;
        @(negedge clk);

        // R2: start while idle
        start = 1; @(negedge clk); start = 0;
        chk(err == 1, "R2 start in idle", err, 1);
        @(negedge clk);

        // R10: abort in idle ignored
        abort = 1; @(negedge clk); abort = 0;
        chk(err == 0 && !mem_req, "R10 abort in idle ignored", err, 0);

        // R2: start while armed but device not in transfer phase
        do_arm(1, 8'd4, LBA0);
        phase = 0; start = 1; @(negedge clk); start = 0;
        chk(err == 1, "R2 start without transfer phase", err, 1);
        @(negedge clk);

        for (int i = 0; i < NV; i++) run(VECS[i], 0, 0);

        run(VECS[0], 1, 0);   // R5 busy on first fetch
        run(VECS[1], 0, 1);   // R11 second arm while armed

        // R10: abort in the middle of a transfer
        do_arm(1, 8'd4, LBA0);
        phase = 1; start = 1; @(negedge clk); start = 0;
        repeat (10) @(negedge clk);
        abort = 1; @(negedge clk); abort = 0;
        chk(err == 1, "R10 abort gives err", err, 1);
        q = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (mem_req || done) q++;
        end
        chk(q == 0, "R10 no requests after abort", q, 0);
        phase = 0;
        run(VECS[2], 0, 0);   // R10 engine usable after abort

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule